// File: doc/BRIEF.md
# Mode-Filtered Event Counter Bank

This block holds a bank of programmable event counters for a processor core. Each cycle the core may present one event pulse tagged with a counter index. The pulse advances the addressed counter, but only when that counter exists, is not stopped by the global stop mask, and is not filtered out for the privilege level the core is running at. Every counter carries five filter bits, one for each execution level: machine, supervisor, user, virtual supervisor and virtual user. It also carries a sticky overflow flag.

The counters are 64 bits wide. They can be read in two layouts, picked by the `narrowMode` input. In the wide layout each counter and its flag word are single registers. In the narrow layout each counter is seen as a low half and a high half, and its flags sit in an upper flag word. When a counter wraps and its overflow flag was clear, the flag is set and the shared interrupt `irqPending` goes high. The interrupt stays high until software pulses `irqClr`.

Registers are picked with `regSel` and an index. Writes take one cycle. Reads are combinational.

Top module: `perfCounterBank`

## Requirements
- R1: An event pulse is dropped when its index is below 3, when it is at or above NUM_CTR, or when the index's bit in AVAIL_MASK is clear. Absent counters always read as zero.
- R2: `regSel` = 4 writes the global stop mask from `regWrData` bit i for counter i. While bit i is set, events for counter i are dropped. Clearing the bit lets counting resume.
- R3: An event is dropped when the counter's filter bit for the current level is set. The level is taken from `privMode` and `virtOn`. `privMode` 3 means machine, and `virtOn` is ignored there. `privMode` 1 means supervisor, or virtual supervisor when `virtOn` is 1. `privMode` 0 means user, or virtual user when `virtOn` is 1.
- R4: In the wide layout an accepted event adds one to the full 64-bit counter, carrying across bit 32. A counter holding all ones goes to zero.
- R5: In the narrow layout an accepted event adds one to the low half if the low half is not all ones. Otherwise it adds one to the high half and leaves the low half at all ones.
- R6: In the narrow layout, when both halves hold all ones, an accepted event clears both halves to zero.
- R7: On a wrap (R4 or R6), if the counter's overflow flag was clear, the flag is set and `irqPending` rises on the same clock edge. A wrap with the flag already set leaves `irqPending` low.
- R8: `irqPending` stays high until `irqClr` is pulsed. Writing the flag word with the overflow bit at zero re-arms interrupt generation for that counter.
- R9: A software write to a counter or to its flag word in the same cycle as an event for that counter wins. The written value is kept and the event is lost.
- R10: Flag word layout, ordered from the MSB down: overflow, machine, supervisor, user, virtual supervisor, virtual user. In the wide layout these occupy bits 63..58 of `regSel` 2. In the narrow layout they occupy bits 31..26 of `regSel` 3, and `regSel` 2 is ignored on write and reads zero. `regSel` 0 is the counter (the low half in the narrow layout). `regSel` 1 is the high half in the narrow layout and is ignored in the wide layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtValid | input | 1 | Event pulse |
| evtIdx | input | 5 | Counter index of the event |
| privMode | input | 2 | Current level (3 machine, 1 supervisor, 0 user) |
| virtOn | input | 1 | Virtualization active |
| narrowMode | input | 1 | 1 = split-half register layout |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 3 | Register select for writes |
| regIdx | input | 5 | Counter index for writes |
| regWrData | input | 64 | Write data |
| rdSel | input | 3 | Register select for reads |
| rdIdx | input | 5 | Counter index for reads |
| rdData | output | 64 | Combinational read data |
| irqClr | input | 1 | Clears the overflow interrupt |
| irqPending | output | 1 | Sticky overflow interrupt |

## Verification
The assertions check, on every cycle, that the increment strobe never fires for an invalid index, a stopped counter, a machine-level filtered counter, or a colliding counter write. They also check that `irqPending` holds until it is cleared and only rises right after an accepted event. The exact counter values are shown only by the bench scenarios: the half-by-half narrow carry, the wraps, flag readback in both layouts, and re-arming after the flag is cleared.

// File: rtl/perfcnt_pkg.sv
package perfcnt_pkg;
  localparam int IDX_W  = 5;
  localparam int FLAG_W = 6;
  // flag bit positions inside the stored flag vector
  localparam int F_OF = 5;
  localparam int F_M  = 4;
  localparam int F_S  = 3;
  localparam int F_U  = 2;
  localparam int F_VS = 1;
  localparam int F_VU = 0;

  typedef enum logic [2:0] {
    SEL_CTR  = 3'd0,
    SEL_CTRH = 3'd1,
    SEL_EVT  = 3'd2,
    SEL_EVTH = 3'd3,
    SEL_INH  = 3'd4
  } regSel_e;

  typedef struct packed {
    logic             incHit;
    logic [IDX_W-1:0] incIdx;
    logic             wrLo;
    logic             wrHi;
    logic             hiFromLow;
    logic             wrFlags;
    logic [IDX_W-1:0] wrIdx;
  } ctlStrobe_t;
endpackage

// File: rtl/perfCounterCtl.sv
module perfCounterCtl
  import perfcnt_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter logic [NUM_CTR-1:0] AVAIL_MASK = 8'h78
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           evtValid,
  input  logic [IDX_W-1:0]               evtIdx,
  input  logic [1:0]                     privMode,
  input  logic                           virtOn,
  input  logic                           narrowMode,
  input  logic                           regWrEn,
  input  logic [2:0]                     regSel,
  input  logic [IDX_W-1:0]               regIdx,
  input  logic [NUM_CTR-1:0]             inhWrVal,
  input  logic                           irqClr,
  input  logic                           ovfNew,
  input  logic [NUM_CTR-1:0][FLAG_W-1:0] flgArr,
  output ctlStrobe_t                     stb,
  output logic [NUM_CTR-1:0]             inhMask,
  output logic                           irqPending
);
  localparam int CI_W = $clog2(NUM_CTR);
  localparam logic [IDX_W-1:0] NUM_IDX = IDX_W'(NUM_CTR);
  localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(3);

  regSel_e sel;
  logic [CI_W-1:0] evtT;
  logic [FLAG_W-1:0] evtFlg;
  logic idxLive, modeBlock, anyCtrWr, collide;

  assign sel    = regSel_e'(regSel);
  assign evtT   = evtIdx[CI_W-1:0];
  assign evtFlg = flgArr[evtT];

  // index must be in range and the counter implemented
  assign idxLive = (evtIdx >= FIRST_IDX) && (evtIdx < NUM_IDX) && AVAIL_MASK[evtT];

  always_comb begin
    unique case (privMode)
      2'b11:   modeBlock = evtFlg[F_M];
      2'b01:   modeBlock = virtOn ? evtFlg[F_VS] : evtFlg[F_S];
      2'b00:   modeBlock = virtOn ? evtFlg[F_VU] : evtFlg[F_U];
      default: modeBlock = 1'b0;
    endcase
  end

  always_comb begin
    stb.wrLo      = regWrEn && (sel == SEL_CTR);
    stb.wrHi      = regWrEn && (((sel == SEL_CTR) && !narrowMode) ||
                                ((sel == SEL_CTRH) && narrowMode));
    stb.hiFromLow = narrowMode;
    stb.wrFlags   = regWrEn && (((sel == SEL_EVT) && !narrowMode) ||
                                ((sel == SEL_EVTH) && narrowMode));
    stb.wrIdx     = regIdx;
    anyCtrWr      = stb.wrLo || stb.wrHi || stb.wrFlags;
    collide       = anyCtrWr && (regIdx == evtIdx);   // R9: software write wins
    stb.incIdx    = evtIdx;
    stb.incHit    = evtValid && idxLive && !inhMask[evtT] && !modeBlock && !collide;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inhMask    <= '0;
      irqPending <= 1'b0;
    end else begin
      if (regWrEn && (sel == SEL_INH)) inhMask <= inhWrVal;
      irqPending <= (irqPending && !irqClr) || ovfNew;
    end
  end
endmodule

// File: rtl/perfCounterPath.sv
module perfCounterPath
  import perfcnt_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter logic [NUM_CTR-1:0] AVAIL_MASK = 8'h78,
  parameter int CTR_W = 64
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctlStrobe_t                     stb,
  input  logic                           narrowMode,
  input  logic [CTR_W-1:0]               wrData,
  input  logic [2:0]                     rdSel,
  input  logic [IDX_W-1:0]               rdIdx,
  input  logic [NUM_CTR-1:0]             inhMask,
  output logic [CTR_W-1:0]               rdData,
  output logic [NUM_CTR-1:0][FLAG_W-1:0] flgArr,
  output logic                           ovfNew
);
  localparam int HALF_W = CTR_W / 2;
  localparam int CI_W = $clog2(NUM_CTR);
  localparam logic [IDX_W-1:0] NUM_IDX = IDX_W'(NUM_CTR);
  localparam logic [HALF_W-1:0] ONE_H = HALF_W'(1);
  localparam logic [CTR_W-1:0]  ONE_C = CTR_W'(1);

  logic [NUM_CTR-1:0][CTR_W-1:0] cntArr;
  logic [NUM_CTR-1:0] ofNewVec;
  logic [FLAG_W-1:0] newFlags;

  assign newFlags = narrowMode ? wrData[HALF_W-1 -: FLAG_W] : wrData[CTR_W-1 -: FLAG_W];

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    if (i >= 3 && AVAIL_MASK[i]) begin : g_live
      logic [CTR_W-1:0] cnt, nextCnt;
      logic [FLAG_W-1:0] flg;
      logic incThis, wrapThis, wrHere;

      assign incThis = stb.incHit && (stb.incIdx == IDX_W'(i));
      assign wrHere  = stb.wrIdx == IDX_W'(i);

      always_comb begin
        nextCnt  = cnt;
        wrapThis = 1'b0;
        if (narrowMode) begin
          if (cnt[HALF_W-1:0] != '1)
            nextCnt[HALF_W-1:0] = cnt[HALF_W-1:0] + ONE_H;
          else if (cnt[CTR_W-1:HALF_W] != '1)
            nextCnt[CTR_W-1:HALF_W] = cnt[CTR_W-1:HALF_W] + ONE_H;
          else begin
            nextCnt  = '0;
            wrapThis = 1'b1;
          end
        end else if (cnt == '1) begin
          nextCnt  = '0;
          wrapThis = 1'b1;
        end else begin
          nextCnt = cnt + ONE_C;
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          cnt <= '0;
          flg <= '0;
        end else begin
          if (wrHere && (stb.wrLo || stb.wrHi)) begin
            if (stb.wrLo) cnt[HALF_W-1:0] <= wrData[HALF_W-1:0];
            if (stb.wrHi) cnt[CTR_W-1:HALF_W] <= stb.hiFromLow ? wrData[HALF_W-1:0]
                                                               : wrData[CTR_W-1:HALF_W];
          end else if (incThis) begin
            cnt <= nextCnt;
          end
          if (wrHere && stb.wrFlags) flg <= newFlags;
          else if (incThis && wrapThis) flg[F_OF] <= 1'b1;
        end
      end

      assign cntArr[i]   = cnt;
      assign flgArr[i]   = flg;
      assign ofNewVec[i] = incThis && wrapThis && !flg[F_OF];
    end else begin : g_absent
      assign cntArr[i]   = '0;
      assign flgArr[i]   = '0;
      assign ofNewVec[i] = 1'b0;
    end
  end

  assign ovfNew = |ofNewVec;

  always_comb begin
    logic [CI_W-1:0] rT;
    logic [CTR_W-1:0] c;
    logic [FLAG_W-1:0] f;
    rT = rdIdx[CI_W-1:0];
    c  = (rdIdx < NUM_IDX) ? cntArr[rT] : '0;
    f  = (rdIdx < NUM_IDX) ? flgArr[rT] : '0;
    rdData = '0;
    unique case (regSel_e'(rdSel))
      SEL_CTR:  if (narrowMode) rdData[HALF_W-1:0] = c[HALF_W-1:0];
                else rdData = c;
      SEL_CTRH: if (narrowMode) rdData[HALF_W-1:0] = c[CTR_W-1:HALF_W];
      SEL_EVT:  if (!narrowMode) rdData[CTR_W-1 -: FLAG_W] = f;
      SEL_EVTH: if (narrowMode) rdData[HALF_W-1 -: FLAG_W] = f;
      SEL_INH:  rdData[NUM_CTR-1:0] = inhMask;
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/perfCounterBank.sv
module perfCounterBank
  import perfcnt_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter logic [NUM_CTR-1:0] AVAIL_MASK = 8'h78,
  parameter int CTR_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evtValid,
  input  logic [IDX_W-1:0] evtIdx,
  input  logic [1:0]       privMode,
  input  logic             virtOn,
  input  logic             narrowMode,
  input  logic             regWrEn,
  input  logic [2:0]       regSel,
  input  logic [IDX_W-1:0] regIdx,
  input  logic [CTR_W-1:0] regWrData,
  input  logic [2:0]       rdSel,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [CTR_W-1:0] rdData,
  input  logic             irqClr,
  output logic             irqPending
);
  ctlStrobe_t ctlStb;
  logic [NUM_CTR-1:0][FLAG_W-1:0] flgArr;
  logic [NUM_CTR-1:0] inhMask;
  logic ovfNew;

  perfCounterCtl #(.NUM_CTR(NUM_CTR), .AVAIL_MASK(AVAIL_MASK)) u_ctl (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtIdx(evtIdx),
    .privMode(privMode), .virtOn(virtOn), .narrowMode(narrowMode),
    .regWrEn(regWrEn), .regSel(regSel), .regIdx(regIdx),
    .inhWrVal(regWrData[NUM_CTR-1:0]), .irqClr(irqClr), .ovfNew(ovfNew),
    .flgArr(flgArr), .stb(ctlStb), .inhMask(inhMask), .irqPending(irqPending)
  );

  perfCounterPath #(.NUM_CTR(NUM_CTR), .AVAIL_MASK(AVAIL_MASK), .CTR_W(CTR_W)) u_path (
    .clk(clk), .rstN(rstN), .stb(ctlStb), .narrowMode(narrowMode),
    .wrData(regWrData), .rdSel(rdSel), .rdIdx(rdIdx), .inhMask(inhMask),
    .rdData(rdData), .flgArr(flgArr), .ovfNew(ovfNew)
  );
endmodule

// File: rtl/perfCounterChk.sv
module perfCounterChk
  import perfcnt_pkg::*;
#(
  parameter int NUM_CTR = 8
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           evtValid,
  input logic [IDX_W-1:0]               evtIdx,
  input logic [1:0]                     privMode,
  input logic                           regWrEn,
  input logic [2:0]                     regSel,
  input logic [IDX_W-1:0]               regIdx,
  input logic                           irqClr,
  input logic                           irqPending,
  input ctlStrobe_t                     ctlStb,
  input logic [NUM_CTR-1:0][FLAG_W-1:0] flgArr,
  input logic [NUM_CTR-1:0]             inhMask
);
  localparam int CI_W = $clog2(NUM_CTR);
  localparam logic [IDX_W-1:0] NUM_IDX = IDX_W'(NUM_CTR);

  p_bad_idx_r1: assert property (@(posedge clk) disable iff (!rstN)
    (evtIdx < IDX_W'(3) || evtIdx >= NUM_IDX) |-> !ctlStb.incHit);

  p_global_stop_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctlStb.incHit |-> !inhMask[ctlStb.incIdx[CI_W-1:0]]);

  p_mach_filter_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctlStb.incHit && privMode == 2'b11) |-> !flgArr[ctlStb.incIdx[CI_W-1:0]][F_M]);

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPending) |-> $past(ctlStb.incHit && evtValid));

  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irqPending && !irqClr) |=> irqPending);

  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == 3'd0 && regIdx == evtIdx) |-> !ctlStb.incHit);
endmodule

bind perfCounterBank perfCounterChk #(.NUM_CTR(NUM_CTR)) u_chk (
  .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtIdx(evtIdx),
  .privMode(privMode), .regWrEn(regWrEn), .regSel(regSel), .regIdx(regIdx),
  .irqClr(irqClr), .irqPending(irqPending), .ctlStb(ctlStb),
  .flgArr(flgArr), .inhMask(inhMask)
);

// File: tb/sim_perfCounterBank.sv
module sim_perfCounterBank;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0;
  logic evtValid = 0, virtOn = 0, narrowMode = 0, regWrEn = 0, irqClr = 0;
  logic [4:0] evtIdx = '0, regIdx = '0, rdIdx = '0;
  logic [1:0] privMode = 2'b11;
  logic [2:0] regSel = '0, rdSel = '0;
  logic [63:0] regWrData = '0, rdData;
  logic irqPending;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perfCounterBank u0 (.*);

  typedef struct packed {
    logic [1:0]  mode;
    logic        virt;
    logic [4:0]  inh;     // M,S,U,VS,VU
    logic [63:0] start;
    logic [63:0] expv;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{2'b11, 1'b0, 5'b00000, 64'd5, 64'd6},
    '{2'b11, 1'b0, 5'b10000, 64'd5, 64'd5},
    '{2'b01, 1'b0, 5'b01000, 64'd7, 64'd7},
    '{2'b01, 1'b1, 5'b01000, 64'd7, 64'd8},
    '{2'b01, 1'b1, 5'b00010, 64'd7, 64'd7},
    '{2'b00, 1'b0, 5'b00100, 64'd9, 64'd9},
    '{2'b00, 1'b1, 5'b00100, 64'd9, 64'd10},
    '{2'b00, 1'b1, 5'b00001, 64'd9, 64'd9},
    '{2'b00, 1'b0, 5'b00001, 64'd9, 64'd10},
    '{2'b11, 1'b1, 5'b01111, 64'h0000_0000_FFFF_FFFF, 64'h0000_0001_0000_0000}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [4:0] i, input logic [63:0] d);
    @(negedge clk);
    regWrEn = 1; regSel = s; regIdx = i; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic evt(input logic [4:0] i);
    @(negedge clk);
    evtValid = 1; evtIdx = i;
    @(negedge clk);
    evtValid = 0;
  endtask

  task automatic rd(input logic [2:0] s, input logic [4:0] i, output logic [63:0] v);
    rdSel = s; rdIdx = i;
    #1;
    v = rdData;
  endtask

  task automatic clrIrq();
    @(negedge clk); irqClr = 1;
    @(negedge clk); irqClr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // reset state
    check("reset irq", {63'd0, irqPending}, 64'd0);
    rd(3'd0, 5'd3, v); check("reset ctr", v, 64'd0);
    rd(3'd2, 5'd3, v); check("reset flags", v, 64'd0);
    rd(3'd4, 5'd0, v); check("reset stop mask", v, 64'd0);

    // R3 R4 table of filter cases in the wide layout
    foreach (VECS[k]) begin
      privMode = VECS[k].mode; virtOn = VECS[k].virt;
      wr(3'd0, 5'd3, VECS[k].start);
      wr(3'd2, 5'd3, {1'b0, VECS[k].inh, 58'd0});
      evt(5'd3);
      rd(3'd0, 5'd3, v);
      check($sformatf("R3/R4 vector %0d", k), v, VECS[k].expv);
    end
    privMode = 2'b11; virtOn = 0;
    wr(3'd2, 5'd3, 64'd0);

    // R1 invalid indices
    wr(3'd0, 5'd3, 64'd20);
    wr(3'd0, 5'd2, 64'd55);
    rd(3'd0, 5'd2, v); check("R1 low index reads zero", v, 64'd0);
    evt(5'd2); evt(5'd7); evt(5'd11);
    rd(3'd0, 5'd3, v); check("R1 aliased index ignored", v, 64'd20);
    wr(3'd0, 5'd7, 64'd9);
    rd(3'd0, 5'd7, v); check("R1 absent counter reads zero", v, 64'd0);

    // R2 global stop mask
    wr(3'd4, 5'd0, 64'h8);
    evt(5'd3);
    rd(3'd0, 5'd3, v); check("R2 stopped", v, 64'd20);
    rd(3'd4, 5'd0, v); check("R2 mask readback", v, 64'h8);
    wr(3'd4, 5'd0, 64'h0);
    evt(5'd3);
    rd(3'd0, 5'd3, v); check("R2 resumed", v, 64'd21);

    // R4 R7 wide wrap and overflow
    wr(3'd0, 5'd5, '1);
    evt(5'd5);
    rd(3'd0, 5'd5, v); check("R4 wide wrap", v, 64'd0);
    check("R7 irq on first wrap", {63'd0, irqPending}, 64'd1);
    rd(3'd2, 5'd5, v); check("R10 wide OF bit", v, 64'h8000_0000_0000_0000);
    clrIrq();
    check("R8 irq cleared", {63'd0, irqPending}, 64'd0);
    wr(3'd0, 5'd5, '1);
    evt(5'd5);
    check("R7 no irq while OF set", {63'd0, irqPending}, 64'd0);
    wr(3'd2, 5'd5, 64'd0);
    wr(3'd0, 5'd5, '1);
    evt(5'd5);
    check("R8 re-armed irq", {63'd0, irqPending}, 64'd1);
    repeat (3) @(negedge clk);
    check("R8 irq holds", {63'd0, irqPending}, 64'd1);
    clrIrq();

    // R5 R6 narrow layout
    narrowMode = 1;
    wr(3'd0, 5'd6, 64'h0000_0000_FFFF_FFFE);
    wr(3'd1, 5'd6, 64'd0);
    wr(3'd3, 5'd6, 64'd0);
    evt(5'd6);
    rd(3'd0, 5'd6, v); check("R5 low step", v, 64'hFFFF_FFFF);
    rd(3'd1, 5'd6, v); check("R5 high untouched", v, 64'd0);
    evt(5'd6);
    rd(3'd0, 5'd6, v); check("R5 low kept at ones", v, 64'hFFFF_FFFF);
    rd(3'd1, 5'd6, v); check("R5 high step", v, 64'd1);
    wr(3'd1, 5'd6, 64'hFFFF_FFFF);
    evt(5'd6);
    rd(3'd0, 5'd6, v); check("R6 low wrap", v, 64'd0);
    rd(3'd1, 5'd6, v); check("R6 high wrap", v, 64'd0);
    check("R7 narrow irq", {63'd0, irqPending}, 64'd1);
    rd(3'd3, 5'd6, v); check("R10 narrow OF bit", v, 64'h8000_0000);
    rd(3'd2, 5'd6, v); check("R10 narrow low flag word zero", v, 64'd0);
    clrIrq();
    wr(3'd3, 5'd6, 64'h4000_0000);
    wr(3'd2, 5'd6, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(3'd3, 5'd6, v); check("R10 wide flag write ignored in narrow", v, 64'h4000_0000);
    evt(5'd6);
    rd(3'd0, 5'd6, v); check("R3 narrow machine filter", v, 64'd0);
    narrowMode = 0;

    // R9 write priority
    @(negedge clk);
    regWrEn = 1; regSel = 3'd0; regIdx = 5'd4; regWrData = 64'd500;
    evtValid = 1; evtIdx = 5'd4;
    @(negedge clk);
    regWrEn = 0; evtValid = 0;
    rd(3'd0, 5'd4, v); check("R9 counter write wins", v, 64'd500);
    @(negedge clk);
    regWrEn = 1; regSel = 3'd2; regIdx = 5'd4; regWrData = 64'd0;
    evtValid = 1; evtIdx = 5'd4;
    @(negedge clk);
    regWrEn = 0; evtValid = 0;
    rd(3'd0, 5'd4, v); check("R9 flag write wins", v, 64'd500);
    evt(5'd4);
    rd(3'd0, 5'd4, v); check("R9 later event counts", v, 64'd501);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule